// File: doc/BRIEF.md
# ASID-Tagged IOTLB with Selective Invalidation

This block is the translation cache of an I/O memory management unit. Each entry is keyed by an address-space identifier (ASID) and a 64-bit input virtual address. It stores the output address, an address mask (2^granule - 1 for a page) and a two-bit permission field. A page-table walker that sits outside this block writes completed translations through the fill port. Device traffic queries the cache through the lookup port, which answers one cycle later with hit or miss and the stored fields.

The array is set-associative with 16 sets of 4 ways by default. The set index comes from a Jenkins-style avalanche of three 32-bit words: the ASID, the low address half and the high address half. A command port removes entries in one of three ways: everything, every entry of one ASID, or one exact (ASID, address) entry. The per-ASID form visits one set per cycle. While it runs, the block raises `busy` and holds off lookups, fills and further commands.

Top module: `iotlb_cache`

## Requirements
- R1: Reset empties the cache. After reset `busy` is 0, `lk_ready` is 1, `rsp_valid` is 0, and every lookup misses.
- R2: An accepted lookup (`lk_valid` with `lk_ready`) produces `rsp_valid` in the next cycle. `rsp_hit` is 1 only when a valid entry's ASID and its full 64-bit address both equal the requested pair. On a hit, `rsp_oa`, `rsp_mask` and `rsp_perm` carry that entry's fields. On a miss they are 0.
- R3: A fill whose (ASID, address) pair already exists overwrites that entry's fields in place, so no duplicate is created.
- R4: A fill of a new pair goes to the lowest-numbered invalid way of its set and leaves the set's replacement pointer unchanged. When all ways are valid, it replaces the way named by the set's round-robin pointer (0 after reset), and the pointer then advances by one, modulo the number of ways.
- R5: Invalidate-all (`inv_kind` = 2'b01) removes every valid entry, whatever its ASID, at the accepting clock edge.
- R6: Invalidate-by-ASID (`inv_kind` = 2'b10) removes every entry whose ASID equals `inv_asid` and keeps every other entry. `busy` is high for exactly SETS cycles, starting in the cycle after acceptance, and `lk_ready` is low whenever `busy` is high.
- R7: Invalidate-by-address (`inv_kind` = 2'b11) removes only the entry whose ASID equals `inv_asid` and whose address equals `inv_va`. Entries of the same ASID at other addresses, and entries of other ASIDs at the same address, remain.
- R8: The set index is the low log2(SETS) bits of c, computed as follows. a, b and c start at the seed 32'hDEADBEF7. Then a += ASID, b += va[31:0] and c += va[63:32]. Then, with rol a 32-bit left rotate, apply in order: c^=b, c-=rol(b,14); a^=c, a-=rol(c,11); b^=a, b-=rol(a,25); c^=b, c-=rol(b,16); a^=c, a-=rol(c,4); b^=a, b-=rol(a,14); c^=b, c-=rol(b,24).
- R9: While `busy` is high, fills and commands are dropped. A fill in the same cycle as an accepted command of a nonzero kind is dropped. A command with `inv_kind` = 2'b00 is a no-op that neither removes entries nor blocks a fill.
- R10: A lookup and a fill in the same cycle: the lookup sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 16 | Lookup ASID |
| lk_va | input | 64 | Lookup input address |
| lk_ready | output | 1 | Lookup can be accepted (not busy) |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_oa | output | 48 | Translated output address |
| rsp_mask | output | 48 | Stored address mask |
| rsp_perm | output | 2 | Stored permissions |
| fill_valid | input | 1 | Write a translation |
| fill_asid | input | 16 | Fill ASID |
| fill_va | input | 64 | Fill input address |
| fill_oa | input | 48 | Fill output address |
| fill_mask | input | 48 | Fill address mask |
| fill_perm | input | 2 | Fill permissions |
| inv_valid | input | 1 | Invalidation command |
| inv_kind | input | 2 | 00 none, 01 all, 10 by ASID, 11 by ASID and address |
| inv_asid | input | 16 | Command ASID |
| inv_va | input | 64 | Command address |
| busy | output | 1 | Per-ASID sweep in progress |

## Verification
A table of fills and lookups separates keys that differ only in ASID, only in the low address bits, or only in the high address half, so that a partial tag compare shows up as a false hit. Directed sequences then build entries with shared ASIDs and shared addresses and issue each command kind, to show that each kind removes exactly its target set of entries. A search for six addresses that hash to one set drives that set through filling, round-robin eviction and refilling a hole, so a pointer that moves when no entry is evicted changes which key survives. Commands and fills issued during a sweep, fills issued in the same cycle as a command, and a same-cycle fill and lookup cover the ordering rules.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

    localparam int ASID_W = 16;
    localparam int VA_W   = 64;
    localparam int OA_W   = 48;
    localparam int PERM_W = 2;

    typedef enum logic [1:0] {
        INV_NONE = 2'b00,
        INV_ALL  = 2'b01,
        INV_ASID = 2'b10,
        INV_ADDR = 2'b11
    } inv_kind_e;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   va;
        logic [OA_W-1:0]   oa;
        logic [OA_W-1:0]   mask;
        logic [PERM_W-1:0] perm;
    } entry_t;

    function automatic logic [31:0] rotl32(input logic [31:0] x, input int unsigned k);
        return (x << k) | (x >> (32 - k));
    endfunction

    // Avalanche of three seeded words; returns the final c word.
    function automatic logic [31:0] key_mix(input logic [31:0] seed,
                                            input logic [ASID_W-1:0] asid,
                                            input logic [VA_W-1:0] va);
        logic [31:0] a, b, c;
        a = seed + 32'(asid);
        b = seed + va[31:0];
        c = seed + va[63:32];
        c = c ^ b; c = c - rotl32(b, 14);
        a = a ^ c; a = a - rotl32(c, 11);
        b = b ^ a; b = b - rotl32(a, 25);
        c = c ^ b; c = c - rotl32(b, 16);
        a = a ^ c; a = a - rotl32(c, 4);
        b = b ^ a; b = b - rotl32(a, 14);
        c = c ^ b; c = c - rotl32(b, 24);
        return c;
    endfunction

endpackage

// File: rtl/iotlb_hash.sv
module iotlb_hash
    import iotlb_pkg::*;
#(
    parameter int          SET_W = 4,
    parameter logic [31:0] SEED  = 32'hDEADBEF7
) (
    input  logic [ASID_W-1:0] asid,
    input  logic [VA_W-1:0]   va,
    output logic [SET_W-1:0]  idx
);
    logic [31:0] mixed;

    always_comb begin
        mixed = key_mix(SEED, asid, va);
        idx   = mixed[SET_W-1:0];
    end
endmodule

// File: rtl/iotlb_way_match.sv
module iotlb_way_match
    import iotlb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  entry_t [WAYS-1:0] ents,
    input  logic [WAYS-1:0]   vld,
    input  logic [ASID_W-1:0] asid,
    input  logic [VA_W-1:0]   va,
    output logic [WAYS-1:0]   hit
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit[w] = vld[w] && (ents[w].asid == asid) && (ents[w].va == va);
    end
endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
    parameter int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  vld,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] way,
    output logic             evict
);
    always_comb begin
        evict = &vld;
        way   = rr_ptr;
        if (!evict) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!vld[w]) way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
    import iotlb_pkg::*;
#(
    parameter int          SETS = 16,
    parameter int          WAYS = 4,
    parameter logic [31:0] SEED = 32'hDEADBEF7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [OA_W-1:0]   rsp_oa,
    output logic [OA_W-1:0]   rsp_mask,
    output logic [PERM_W-1:0] rsp_perm,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [OA_W-1:0]   fill_oa,
    input  logic [OA_W-1:0]   fill_mask,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              inv_valid,
    input  logic [1:0]        inv_kind,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VA_W-1:0]   inv_va,
    output logic              busy
);
    localparam int SET_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int ENTRIES = SETS * WAYS;

    entry_t [WAYS-1:0]  ent_q [SETS];
    logic [ENTRIES-1:0] valid_q;
    logic [WAY_W-1:0]   rr_q  [SETS];
    logic               busy_q;
    logic [SET_W-1:0]   sweep_q;
    logic [ASID_W-1:0]  sweep_asid_q;

    logic               rsp_valid_q, rsp_hit_q;
    logic [OA_W-1:0]    rsp_oa_q, rsp_mask_q;
    logic [PERM_W-1:0]  rsp_perm_q;

    logic [SET_W-1:0]   lk_idx, fill_idx, inv_idx;
    logic [WAYS-1:0]    lk_vld, fill_vld, inv_vld, sweep_vld;
    logic [WAYS-1:0]    lk_hitv, fill_hitv, inv_hitv, sweep_hitv;
    logic [WAY_W-1:0]   vic_way;
    logic               vic_evict;
    logic               lk_acc, inv_acc, fill_acc;
    inv_kind_e          kind;
    entry_t             lk_sel, fill_ent;

    // Set index per port
    iotlb_hash #(.SET_W(SET_W), .SEED(SEED)) u_hash_lk
        (.asid(lk_asid), .va(lk_va), .idx(lk_idx));
    iotlb_hash #(.SET_W(SET_W), .SEED(SEED)) u_hash_fill
        (.asid(fill_asid), .va(fill_va), .idx(fill_idx));
    iotlb_hash #(.SET_W(SET_W), .SEED(SEED)) u_hash_inv
        (.asid(inv_asid), .va(inv_va), .idx(inv_idx));

    always_comb begin
        lk_vld    = valid_q[int'(lk_idx) * WAYS +: WAYS];
        fill_vld  = valid_q[int'(fill_idx) * WAYS +: WAYS];
        inv_vld   = valid_q[int'(inv_idx) * WAYS +: WAYS];
        sweep_vld = valid_q[int'(sweep_q) * WAYS +: WAYS];
    end

    iotlb_way_match #(.WAYS(WAYS)) u_match_lk
        (.ents(ent_q[lk_idx]), .vld(lk_vld), .asid(lk_asid), .va(lk_va), .hit(lk_hitv));
    iotlb_way_match #(.WAYS(WAYS)) u_match_fill
        (.ents(ent_q[fill_idx]), .vld(fill_vld), .asid(fill_asid), .va(fill_va), .hit(fill_hitv));
    iotlb_way_match #(.WAYS(WAYS)) u_match_inv
        (.ents(ent_q[inv_idx]), .vld(inv_vld), .asid(inv_asid), .va(inv_va), .hit(inv_hitv));

    for (genvar w = 0; w < WAYS; w++) begin : g_sweep
        assign sweep_hitv[w] = sweep_vld[w] && (ent_q[sweep_q][w].asid == sweep_asid_q);
    end

    iotlb_victim #(.WAYS(WAYS)) u_victim
        (.vld(fill_vld), .rr_ptr(rr_q[fill_idx]), .way(vic_way), .evict(vic_evict));

    always_comb begin
        kind     = inv_kind_e'(inv_kind);
        lk_acc   = lk_valid && !busy_q;
        inv_acc  = inv_valid && !busy_q && (kind != INV_NONE);
        fill_acc = fill_valid && !busy_q && !inv_acc;
        fill_ent = '{asid: fill_asid, va: fill_va, oa: fill_oa,
                     mask: fill_mask, perm: fill_perm};
        lk_sel   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_hitv[w]) lk_sel = lk_sel | ent_q[lk_idx][w];
        end
    end

    // Response register
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_oa_q    <= '0;
            rsp_mask_q  <= '0;
            rsp_perm_q  <= '0;
        end else begin
            rsp_valid_q <= lk_acc;
            rsp_hit_q   <= lk_acc && (|lk_hitv);
            rsp_oa_q    <= lk_acc ? lk_sel.oa   : '0;
            rsp_mask_q  <= lk_acc ? lk_sel.mask : '0;
            rsp_perm_q  <= lk_acc ? lk_sel.perm : '0;
        end
    end

    // Array contents, sweep and replacement state
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q      <= '0;
            busy_q       <= 1'b0;
            sweep_q      <= '0;
            sweep_asid_q <= '0;
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (busy_q) begin
            for (int w = 0; w < WAYS; w++) begin
                if (sweep_hitv[w]) valid_q[int'(sweep_q) * WAYS + w] <= 1'b0;
            end
            if (sweep_q == SET_W'(SETS - 1)) busy_q <= 1'b0;
            else                             sweep_q <= sweep_q + 1'b1;
        end else if (inv_acc) begin
            unique case (kind)
                INV_ALL:  valid_q <= '0;
                INV_ASID: begin
                    busy_q       <= 1'b1;
                    sweep_q      <= '0;
                    sweep_asid_q <= inv_asid;
                end
                INV_ADDR: begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (inv_hitv[w]) valid_q[int'(inv_idx) * WAYS + w] <= 1'b0;
                    end
                end
                default: ;
            endcase
        end else if (fill_acc) begin
            if (|fill_hitv) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (fill_hitv[w]) ent_q[fill_idx][w] <= fill_ent;
                end
            end else begin
                ent_q[fill_idx][vic_way] <= fill_ent;
                valid_q[int'(fill_idx) * WAYS + int'(vic_way)] <= 1'b1;
                if (vic_evict) begin
                    rr_q[fill_idx] <= (int'(rr_q[fill_idx]) == WAYS - 1)
                                      ? '0 : rr_q[fill_idx] + 1'b1;
                end
            end
        end
    end

    assign lk_ready  = !busy_q;
    assign busy      = busy_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_oa    = rsp_oa_q;
    assign rsp_mask  = rsp_mask_q;
    assign rsp_perm  = rsp_perm_q;
endmodule

// File: rtl/iotlb_cache_chk.sv
module iotlb_cache_chk #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int ENTRIES = SETS * WAYS
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic               lk_ready,
    input logic               rsp_valid,
    input logic               inv_valid,
    input logic [1:0]         inv_kind,
    input logic               busy,
    input logic [WAYS-1:0]    lk_hitv,
    input logic [ENTRIES-1:0] valid_q
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $past(rst) && !rst |-> !busy && !rsp_valid && valid_q == '0);

    a_r2_rsp_follows_accept: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready) |=> rsp_valid);

    a_r2_no_rsp_without_accept: assert property (@(posedge clk) disable iff (rst)
        !(lk_valid && lk_ready) |=> !rsp_valid);

    a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hitv));

    a_r5_all_cleared: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !busy && inv_kind == 2'b01) |=> valid_q == '0);

    a_r6_busy_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(inv_valid && inv_kind == 2'b10));

    a_r6_busy_bound: assert property (@(posedge clk) disable iff (rst)
        busy_run <= SETS);

    a_r6_ready_low: assert property (@(posedge clk) disable iff (rst)
        busy |-> !lk_ready);

    a_r9_no_growth_busy: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $countones(valid_q) <= $past($countones(valid_q)));
endmodule

bind iotlb_cache iotlb_cache_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .inv_valid(inv_valid), .inv_kind(inv_kind),
    .busy(busy), .lk_hitv(lk_hitv), .valid_q(valid_q)
);

// File: tb/test_iotlb_cache.sv
`timescale 1ns/1ps
module test_iotlb_cache;
    localparam int SETS = 16;

    logic clk = 0, rst = 1;
    logic lk_valid = 0, fill_valid = 0, inv_valid = 0;
    logic [15:0] lk_asid = 0, fill_asid = 0, inv_asid = 0;
    logic [63:0] lk_va = 0, fill_va = 0, inv_va = 0;
    logic [47:0] fill_oa = 0, fill_mask = 0;
    logic [1:0]  fill_perm = 0, inv_kind = 0;
    logic lk_ready, rsp_valid, rsp_hit, busy;
    logic [47:0] rsp_oa, rsp_mask;
    logic [1:0]  rsp_perm;
    int errors = 0, checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    iotlb_cache i_iotlb_cache (.*);

    typedef struct packed {
        logic        is_fill;
        logic [15:0] asid;
        logic [63:0] va;
        logic [47:0] oa;
        logic [1:0]  perm;
        logic        exp_hit;
    } vec_t;

    localparam vec_t TABLE [10] = '{
        '{1'b1, 16'd1, 64'h1000, 48'hA000, 2'd3, 1'b0},
        '{1'b1, 16'd2, 64'h1000, 48'hB000, 2'd1, 1'b0},
        '{1'b0, 16'd1, 64'h1000, 48'hA000, 2'd3, 1'b1},
        '{1'b0, 16'd2, 64'h1000, 48'hB000, 2'd1, 1'b1},
        '{1'b0, 16'd3, 64'h1000, 48'h0,    2'd0, 1'b0},
        '{1'b0, 16'd1, 64'h2000, 48'h0,    2'd0, 1'b0},
        '{1'b0, 16'd1, 64'h1001, 48'h0,    2'd0, 1'b0},
        '{1'b1, 16'd1, 64'hFFFF_0000_0000_1000, 48'hC000, 2'd2, 1'b0},
        '{1'b0, 16'd1, 64'hFFFF_0000_0000_1000, 48'hC000, 2'd2, 1'b1},
        '{1'b0, 16'd1, 64'h1000, 48'hA000, 2'd3, 1'b1}
    };

    function automatic logic [31:0] rl(input logic [31:0] x, input int k);
        return (x << k) | (x >> (32 - k));
    endfunction

    // Set index exactly as R8 defines it
    function automatic int set_of(input logic [15:0] asid, input logic [63:0] va);
        logic [31:0] a, b, c;
        a = 32'hDEADBEF7 + {16'h0, asid};
        b = 32'hDEADBEF7 + va[31:0];
        c = 32'hDEADBEF7 + va[63:32];
        c ^= b; c -= rl(b, 14); a ^= c; a -= rl(c, 11);
        b ^= a; b -= rl(a, 25); c ^= b; c -= rl(b, 16);
        a ^= c; a -= rl(c, 4);  b ^= a; b -= rl(a, 14);
        c ^= b; c -= rl(b, 24);
        return int'(c[3:0]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [15:0] a, input logic [63:0] v, input logic [47:0] oa,
                        input logic [1:0] p, input logic [47:0] m = 48'hFFF);
        @(negedge clk);
        fill_valid = 1; fill_asid = a; fill_va = v; fill_oa = oa; fill_perm = p; fill_mask = m;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic inv(input logic [1:0] k, input logic [15:0] a, input logic [63:0] v);
        @(negedge clk);
        inv_valid = 1; inv_kind = k; inv_asid = a; inv_va = v;
        @(negedge clk);
        inv_valid = 0; inv_kind = 0;
    endtask

    task automatic look(input logic [15:0] a, input logic [63:0] v, input bit eh,
                        input logic [47:0] eoa, input logic [1:0] ep, input string req);
        @(negedge clk);
        lk_valid = 1; lk_asid = a; lk_va = v;
        @(negedge clk);
        lk_valid = 0;
        chk(rsp_valid && rsp_hit == eh, req, {62'h0, rsp_valid, rsp_hit}, {62'h0, 1'b1, eh});
        if (eh) chk(rsp_oa == eoa && rsp_perm == ep, req, {14'h0, rsp_perm, rsp_oa}, {14'h0, ep, eoa});
    endtask

    task automatic wait_sweep(output int n);
        n = 0;
        while (busy && n < 1000) begin
            if (lk_ready) chk(0, "R6 lk_ready low while busy", 64'(lk_ready), 0);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] same [6];
        int found, n, tgt;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && lk_ready && !rsp_valid, "R1 idle after reset", {busy, lk_ready, rsp_valid}, 64'b010);
        look(1, 64'h1000, 0, 0, 0, "R1 empty after reset");

        // R2 table walk
        foreach (TABLE[i]) begin
            if (TABLE[i].is_fill) fill(TABLE[i].asid, TABLE[i].va, TABLE[i].oa, TABLE[i].perm);
            else look(TABLE[i].asid, TABLE[i].va, TABLE[i].exp_hit, TABLE[i].oa, TABLE[i].perm, "R2 table lookup");
        end

        // R3 overwrite in place, mask returned
        fill(1, 64'h1000, 48'hD000, 2'd1, 48'h1F_FFFF);
        look(1, 64'h1000, 1, 48'hD000, 2'd1, "R3 overwrite");
        chk(rsp_mask == 48'h1F_FFFF, "R2 mask field", 64'(rsp_mask), 64'h1F_FFFF);
        inv(2'b11, 1, 64'h1000);
        look(1, 64'h1000, 0, 0, 0, "R3 no duplicate left");

        // R10 same-cycle fill and lookup
        @(negedge clk);
        fill_valid = 1; fill_asid = 4; fill_va = 64'h4000; fill_oa = 48'h4400; fill_perm = 3;
        lk_valid = 1; lk_asid = 4; lk_va = 64'h4000;
        @(negedge clk);
        fill_valid = 0; lk_valid = 0;
        chk(rsp_valid && !rsp_hit, "R10 lookup sees old state", 64'(rsp_hit), 0);
        look(4, 64'h4000, 1, 48'h4400, 3, "R10 fill visible next");

        // R7 by-address
        fill(1, 64'h1000, 48'hA000, 3);
        fill(1, 64'h2000, 48'hA200, 3);
        inv(2'b11, 1, 64'h1000);
        look(1, 64'h1000, 0, 0, 0, "R7 target removed");
        look(2, 64'h1000, 1, 48'hB000, 1, "R7 other ASID kept");
        look(1, 64'h2000, 1, 48'hA200, 3, "R7 other address kept");

        // R6 by-ASID sweep
        for (int i = 0; i < 8; i++) fill(5, 64'(i) << 12, 48'h5000 + 48'(i), 2);
        fill(6, 64'h6000, 48'h6000, 1);
        inv(2'b10, 5, 0);
        // R9: fill and command during busy are dropped
        @(negedge clk);
        fill_valid = 1; fill_asid = 9; fill_va = 64'h9000; fill_oa = 48'h9000; fill_perm = 1;
        inv_valid = 1; inv_kind = 2'b01;
        @(negedge clk);
        fill_valid = 0; inv_valid = 0; inv_kind = 0;
        wait_sweep(n);
        chk(n + 2 == SETS, "R6 busy length", 64'(n + 2), 64'(SETS));
        for (int i = 0; i < 8; i++) look(5, 64'(i) << 12, 0, 0, 0, "R6 ASID removed");
        look(6, 64'h6000, 1, 48'h6000, 1, "R6 other ASID kept");
        look(2, 64'h1000, 1, 48'hB000, 1, "R9 inv-all during busy dropped");
        look(9, 64'h9000, 0, 0, 0, "R9 fill during busy dropped");

        // R9 same-cycle fill with command, and no-op kind
        @(negedge clk);
        fill_valid = 1; fill_asid = 9; fill_va = 64'h9000; fill_oa = 48'h9100; fill_perm = 1;
        inv_valid = 1; inv_kind = 2'b11; inv_asid = 6; inv_va = 64'h6000;
        @(negedge clk);
        inv_kind = 2'b00; inv_asid = 2; inv_va = 64'h1000;
        @(negedge clk);
        fill_valid = 0; inv_valid = 0;
        look(9, 64'h9000, 1, 48'h9100, 1, "R9 no-op kind lets fill through");
        look(6, 64'h6000, 0, 0, 0, "R9 command with fill applied");
        look(2, 64'h1000, 1, 48'hB000, 1, "R9 no-op kind removes nothing");

        // R5 invalidate all
        inv(2'b01, 0, 0);
        look(2, 64'h1000, 0, 0, 0, "R5 cleared");
        look(9, 64'h9000, 0, 0, 0, "R5 cleared");
        look(4, 64'h4000, 0, 0, 0, "R5 cleared");

        // R4/R8 replacement in one set
        found = 0;
        tgt = set_of(7, 64'h1000);
        for (int i = 1; i < 4096 && found < 6; i++) begin
            if (set_of(7, 64'(i) << 12) == tgt) begin
                same[found] = 64'(i) << 12;
                found++;
            end
        end
        chk(found == 6, "R8 bench key search", 64'(found), 6);
        for (int i = 0; i < 4; i++) fill(7, same[i], 48'h7000 + 48'(i), 1);
        for (int i = 0; i < 4; i++) look(7, same[i], 1, 48'h7000 + 48'(i), 1, "R4 set fills all ways");
        fill(7, same[4], 48'h7004, 1);
        look(7, same[0], 0, 0, 0, "R4 way0 evicted first");
        look(7, same[4], 1, 48'h7004, 1, "R4 new key present");
        fill(7, same[5], 48'h7005, 1);
        look(7, same[1], 0, 0, 0, "R4 pointer advanced");
        inv(2'b11, 7, same[2]);
        fill(7, same[0], 48'h7010, 1);
        look(7, same[3], 1, 48'h7003, 1, "R4 hole filled, no eviction");
        fill(7, same[1], 48'h7011, 1);
        look(7, same[0], 0, 0, 0, "R4 pointer unchanged by hole fill");
        look(7, same[3], 1, 48'h7003, 1, "R4 survivor");
        look(7, same[5], 1, 48'h7005, 1, "R4 survivor");

        // R1 reset clears contents
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        look(7, same[3], 0, 0, 0, "R1 reset empties");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule